// File: doc/BRIEF.md
# Trace Component Management Register Bank

This block is the small memory-mapped register bank that sits beside a trace output component and manages it. It stores a claim tag that a debugger and application software use to agree on ownership. It also holds a software write lock that is opened with a fixed key, an integration-mode switch, a capture register for the trace-bus handshake inputs, an output-override register, and a programmable start value for an 8-bit reload down-counter.

The bus is a plain single-cycle register port. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`. `bus_priv` marks an access from an external debugger, and such an access is not subject to the software lock. All addresses are word indices.

Top module: `trace_mgmt_regs`

## Requirements
- R1: After reset, the following values hold: integration mode is off, all claim bits are 0, the counter start value is 0xFF, and the lock is engaged when `LOCK_EN`=1. In this state the `trc_ready_o` and `trc_flush_o` pins follow `fn_ready_i` and `fn_flush_i`.
- R2: A write to address 0x4 sets every implemented claim bit (bits [3:0]) whose data bit is 1, and bits above 3 are ignored. A read of address 0x4 returns 0x0000000F, the implemented mask.
- R3: A write to address 0x5 clears every claim bit whose data bit is 1. A read of address 0x5 returns the current claim tag.
- R4: Claim bits are storage only. Changing them leaves every other register and the trace pins unchanged.
- R5: While locked, non-privileged writes to every address other than 0x6 are ignored. Privileged writes take effect.
- R6: A write of 0x5A17C0DE to address 0x6 removes the lock, and a write of any other value there engages it. Address 0x7 reads bit 0 = lock implemented and bit 1 = locked. Address 0x6 reads 0.
- R7: With `LOCK_EN`=0, address 0x7 reads 0 and no write is ever blocked.
- R8: Bit 0 of address 0x0 selects integration mode. In integration mode, `trc_ready_o` and `trc_flush_o` are driven from bits 0 and 1 of address 0x3. Otherwise they follow the functional inputs.
- R9: In integration mode, address 0x2 returns the trace inputs sampled one cycle earlier, laid out as valid in bit 0, flush-ready in bit 1 and byte count in bits [3:2]. The byte-count field reads 0 whenever the captured valid is low. Outside integration mode, address 0x2 reads 0.
- R10: Address 0x1 holds the 8-bit counter start value and reads back the programmed value. The counter decrements each cycle. On reaching 0 it reloads from the start value and pulses `cnt_reload_o` for one cycle, which gives a pulse period of start+1 cycles. A start value of 0 holds the pulse high.
- R11: Address 0x8 reads the constant `DEV_TYPE`, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Privileged (debugger) access, bypasses the lock |
| bus_rdata | output | 32 | Read data |
| trc_valid_i | input | 1 | Trace-bus valid input |
| trc_flush_rdy_i | input | 1 | Trace-bus flush-ready input |
| trc_bytes_i | input | BYTES_W | Trace-bus byte count input |
| fn_ready_i | input | 1 | Functional ready value for the ready pin |
| fn_flush_i | input | 1 | Functional flush request for the flush pin |
| trc_ready_o | output | 1 | Ready pin toward the trace bus |
| trc_flush_o | output | 1 | Flush request pin toward the trace bus |
| cnt_reload_o | output | 1 | One-cycle pulse on counter reload |

## Verification
The bench builds two instances with the default 4-bit claim tag and 2-bit byte count. One has `LOCK_EN`=1 and the other has `LOCK_EN`=0, so locked, unlocked and lockless behaviour can all be compared under the same bus traffic. These small widths let the bench sweep all 16 claim patterns and all 16 capture input combinations. The 8-bit counter lets it measure reload periods for several start values, including 0, within a few hundred cycles.

// File: rtl/trace_mgmt_regs.sv
module trace_mgmt_regs #(
  parameter int          ADDR_W     = 4,
  parameter int          CLAIM_W    = 4,
  parameter int          CNT_W      = 8,
  parameter int          BYTES_W    = 2,
  parameter bit          LOCK_EN    = 1'b1,
  parameter logic [31:0] UNLOCK_KEY = 32'h5A17_C0DE,
  parameter logic [31:0] DEV_TYPE   = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_priv,
  output logic [31:0]       bus_rdata,
  input  logic              trc_valid_i,
  input  logic              trc_flush_rdy_i,
  input  logic [BYTES_W-1:0] trc_bytes_i,
  input  logic              fn_ready_i,
  input  logic              fn_flush_i,
  output logic              trc_ready_o,
  output logic              trc_flush_o,
  output logic              cnt_reload_o
);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CAPT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_OVR   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CSET  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CCLR  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_TYPE  = ADDR_W'(8);
  localparam int CAPT_W = BYTES_W + 2;

  logic               integ_q;
  logic [CNT_W-1:0]   start_q, cnt_q;
  logic [1:0]         ovr_q;
  logic [CLAIM_W-1:0] claim_q;
  logic               locked_q;
  logic [CAPT_W-1:0]  capt_q;
  logic               pulse_q;

  wire wr_ok  = bus_we && (!locked_q || bus_priv);
  wire wr_key = bus_we && (bus_addr == A_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q  <= 1'b0;
      start_q  <= '1;
      ovr_q    <= '0;
      claim_q  <= '0;
      locked_q <= LOCK_EN;
    end else begin
      if (wr_ok && bus_addr == A_MODE)  integ_q <= bus_wdata[0];
      if (wr_ok && bus_addr == A_START) start_q <= bus_wdata[CNT_W-1:0];
      if (wr_ok && bus_addr == A_OVR)   ovr_q   <= bus_wdata[1:0];
      if (wr_ok && bus_addr == A_CSET)  claim_q <= claim_q | bus_wdata[CLAIM_W-1:0];
      if (wr_ok && bus_addr == A_CCLR)  claim_q <= claim_q & ~bus_wdata[CLAIM_W-1:0];
      if (wr_key) locked_q <= LOCK_EN && (bus_wdata != UNLOCK_KEY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) capt_q <= '0;
    else if (!integ_q) capt_q <= '0;
    else capt_q <= {trc_valid_i ? trc_bytes_i : BYTES_W'(0), trc_flush_rdy_i, trc_valid_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      pulse_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q   <= start_q;
      pulse_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q - 1'b1;
      pulse_q <= 1'b0;
    end
  end

  assign cnt_reload_o = pulse_q;
  assign trc_ready_o  = integ_q ? ovr_q[0] : fn_ready_i;
  assign trc_flush_o  = integ_q ? ovr_q[1] : fn_flush_i;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:  bus_rdata[0] = integ_q;
      A_START: bus_rdata[CNT_W-1:0] = start_q;
      A_CAPT:  bus_rdata[CAPT_W-1:0] = capt_q;
      A_OVR:   bus_rdata[1:0] = ovr_q;
      A_CSET:  bus_rdata[CLAIM_W-1:0] = '1;
      A_CCLR:  bus_rdata[CLAIM_W-1:0] = claim_q;
      A_STAT:  bus_rdata[1:0] = {locked_q, LOCK_EN};
      A_TYPE:  bus_rdata = DEV_TYPE;
      default: bus_rdata = '0;
    endcase
  end

  a_r5_locked_start_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !bus_priv && bus_we && bus_addr == A_START) |=> $stable(start_q));
  a_r7_no_lock_never_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !LOCK_EN |-> !locked_q);
  a_r2_r3_claim_only_by_views: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == A_CSET || bus_addr == A_CCLR)) |=> $stable(claim_q));
  a_r9_bytes_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !capt_q[0] |-> capt_q[CAPT_W-1:2] == '0);
  a_r9_capture_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !integ_q |=> capt_q == '0);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && cnt_q != '0) |=> !pulse_q);
  a_r10_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> cnt_q == $past(start_q));
endmodule

// File: tb/trace_mgmt_regs_tb.sv
`timescale 1ns/1ps
module trace_mgmt_regs_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic we = 1'b0, priv = 1'b0;
  logic [31:0] wdata = '0, rdata, rdata_nl;
  logic tv = 0, tf = 0, fr = 0, ff = 0;
  logic [1:0] tb_bytes = '0;
  logic rdy, fl, pulse, rdy_nl, fl_nl, pulse_nl;
  int errors = 0, checks = 0;
  localparam logic [31:0] KEY = 32'h5A17_C0DE;

  always #2.5 clk = ~clk;

  trace_mgmt_regs u_dut (.clk, .rst_n, .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_priv(priv), .bus_rdata(rdata), .trc_valid_i(tv), .trc_flush_rdy_i(tf),
    .trc_bytes_i(tb_bytes), .fn_ready_i(fr), .fn_flush_i(ff), .trc_ready_o(rdy),
    .trc_flush_o(fl), .cnt_reload_o(pulse));
  trace_mgmt_regs #(.LOCK_EN(1'b0)) u_nolock (.clk, .rst_n, .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_priv(priv), .bus_rdata(rdata_nl), .trc_valid_i(tv),
    .trc_flush_rdy_i(tf), .trc_bytes_i(tb_bytes), .fn_ready_i(fr), .fn_flush_i(ff),
    .trc_ready_o(rdy_nl), .trc_flush_o(fl_nl), .cnt_reload_o(pulse_nl));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic p);
    @(negedge clk); addr = a; wdata = d; priv = p; we = 1'b1;
    @(negedge clk); we = 1'b0; priv = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic [31:0] dn);
    @(negedge clk); addr = a; #1; d = rdata; dn = rdata_nl;
  endtask

  task automatic period(input int s, input string tag);
    int n;
    wr(4'h1, 32'(s), 1'b1);
    do @(negedge clk); while (!pulse);
    do @(negedge clk); while (!pulse);
    n = 0;
    do begin @(negedge clk); n++; end while (!pulse);
    chk(tag, 32'(n), 32'(s + 1));
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, dn;
    logic [3:0] tag_exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'h0, d, dn); chk("R1 mode", d, 0);
    rd(4'h5, d, dn); chk("R1 claim", d, 0);
    rd(4'h1, d, dn); chk("R1 start", d, 32'hFF);
    rd(4'h7, d, dn); chk("R1 locked status", d, 32'h3);
    chk("R7 status no lock", dn, 0);
    fr = 1; ff = 0; #1;
    chk("R1 ready follows fn", {31'b0, rdy}, 1);
    chk("R1 flush follows fn", {31'b0, fl}, 0);
    // R11
    rd(4'h8, d, dn); chk("R11 type", d, 32'h11);
    rd(4'hC, d, dn); chk("R11 unmapped", d, 0);
    rd(4'h4, d, dn); chk("R2 mask", d, 32'hF);
    // R5 locked ignore
    wr(4'h1, 32'h22, 1'b0);
    rd(4'h1, d, dn); chk("R5 locked write ignored", d, 32'hFF);
    chk("R7 no-lock write taken", dn, 32'h22);
    wr(4'h4, 32'hF, 1'b0);
    rd(4'h5, d, dn); chk("R5 locked claim ignored", d, 0);
    wr(4'h1, 32'h33, 1'b1);
    rd(4'h1, d, dn); chk("R5 privileged write", d, 32'h33);
    // R6 key
    wr(4'h6, KEY, 1'b0);
    rd(4'h7, d, dn); chk("R6 unlocked status", d, 32'h1);
    rd(4'h6, d, dn); chk("R6 key reads 0", d, 0);
    wr(4'h1, 32'h44, 1'b0);
    rd(4'h1, d, dn); chk("R6 write after unlock", d, 32'h44);
    wr(4'h6, KEY ^ 32'h1, 1'b0);
    rd(4'h7, d, dn); chk("R6 relocked", d, 32'h3);
    wr(4'h1, 32'h55, 1'b0);
    rd(4'h1, d, dn); chk("R6 relock blocks", d, 32'h44);
    wr(4'h6, KEY, 1'b1);
    // R2/R3 sweep
    tag_exp = '0;
    for (int i = 0; i < 16; i++) begin
      wr(4'h4, 32'hFFFF_FFF0 | i, 1'b0);
      tag_exp |= 4'(i);
      rd(4'h5, d, dn); chk("R2 claim set", d, {28'b0, tag_exp});
      wr(4'h5, 32'(i ^ 5), 1'b0);
      tag_exp &= ~4'(i ^ 5);
      rd(4'h5, d, dn); chk("R3 claim clear", d, {28'b0, tag_exp});
    end
    // R4 claim no effect
    wr(4'h4, 32'hF, 1'b0);
    rd(4'h1, d, dn); chk("R4 start kept", d, 32'h44);
    rd(4'h0, d, dn); chk("R4 mode kept", d, 0);
    rd(4'h7, d, dn); chk("R4 lock kept", d, 32'h1);
    chk("R4 pins kept", {30'b0, fl, rdy}, 32'h1);
    // R8 integration
    wr(4'h3, 32'h2, 1'b0);
    chk("R8 functional ignores override", {30'b0, fl, rdy}, 32'h1);
    wr(4'h0, 32'h1, 1'b0);
    #1; chk("R8 override pins", {30'b0, fl, rdy}, 32'h2);
    // R9 capture sweep
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); {tb_bytes, tf, tv} = 4'(i);
      @(negedge clk);
      rd(4'h2, d, dn);
      chk("R9 capture", d, tv ? 32'(i) : 32'(i & 2));
    end
    wr(4'h0, 32'h0, 1'b0);
    @(negedge clk);
    rd(4'h2, d, dn); chk("R9 capture off", d, 0);
    #1; chk("R8 back to functional", {30'b0, fl, rdy}, 32'h1);
    // R10 counter
    period(3, "R10 period 3");
    period(1, "R10 period 1");
    period(7, "R10 period 7");
    rd(4'h1, d, dn); chk("R10 start readback", d, 7);
    wr(4'h1, 0, 1'b0);
    do @(negedge clk); while (!pulse);
    repeat (10) @(negedge clk);
    repeat (5) begin @(negedge clk); chk("R10 start zero holds pulse", {31'b0, pulse}, 1); end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule